// File: doc/BRIEF.md
# Serial Peripheral Slave with Justified Shift Register

This block is the slave end of a four-wire serial link in clock mode 0, where data is sampled on the rising clock edge and changed on the falling edge. While the select input is low, every serial clock moves one bit in from MOSI and one bit out on MISO, whether or not the local CPU has prepared anything. Receive data passes through a 16-bit shift register that is never cleared. For characters shorter than 16 bits, the bits above the newest character are therefore the tail of earlier traffic. Transmit words are written left-justified: the first bit to leave always sits at bit 15, whatever the character length.

A four-entry transmit queue decouples the CPU from the serial timing. When the queue is empty at the start of a character, zeros go out and a sticky underrun flag records the event. A ready output drops in hardware as soon as the slave cannot supply another character or hold another received one. The serial master can use it for flow control without any CPU involvement. The serial pins are synchronised into the system clock domain, which must run at least four times faster than the serial clock.

The CPU sees four word registers on a small parallel port:
- address 0 pushes transmit data.
- address 1 returns the receive register.
- address 2 holds control.
- address 3 holds status.

Top module: `spi_jslave`

## Requirements
- R1: Each rising SCLK edge while CS_n is low shifts the MOSI bit into bit 0 of a 16-bit receive shift register, moving the older bits left. Only reset clears this register.
- R2: The character length is CTRL[3:0]+1 clocks (1 to 16), reset value 7 (8 bits). A character completes on the rising edge that brings its bit count to that length, and the next character starts on the following falling edge.
- R3: Transmit words are left-justified. Bit 15 of the loaded word appears on MISO when the character starts, and each falling SCLK edge moves the next lower bit onto MISO.
- R4: When a character completes, the whole 16-bit shift register is copied into the receive register (read at address 1). The newest character is right-justified and earlier bits remain above it.
- R5: A rising CS_n edge copies the shift register into the receive register, even when the character in progress is incomplete. This copy does not set the receive-full flag.
- R6: If the transmit queue is empty when a character starts, that character is all zeros. Its first clock sets the underrun flag STATUS[2], and writing 1 to STATUS[2] clears it.
- R7: The transmit queue holds 4 words. A write to address 0 while the queue is full is ignored. STATUS[6:4] gives the fill level and STATUS[7] flags a full queue.
- R8: irq_tx_o is high whenever the fill level is less than or equal to the threshold CTRL[5:4] (reset value 0).
- R9: A completed character sets the receive-full flag STATUS[0] and drives irq_rx_o high. Reading address 1 clears both.
- R10: A character that completes while receive-full is still set also sets the overrun flag STATUS[1]. Writing 1 to STATUS[1] clears it.
- R11: ready_o is high only while the transmit queue holds at least one word and receive-full is clear.
- R12: miso_oe_o is high only while the synchronised CS_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x SCLK |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from master |
| cs_ni | input | 1 | Active-low chip select |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Output enable for MISO pad |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (side effects on address 1) |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, combinational from address |
| irq_tx_o | output | 1 | Transmit level interrupt |
| irq_rx_o | output | 1 | Receive full interrupt |
| ready_o | output | 1 | Hardware flow-control ready |

## Verification
The bound assertions check the following on every cycle:
- the queue level stays within its depth, and a push into a full queue leaves it unchanged;
- MISO moves only on a falling serial edge or at select;
- every underrun event leaves the sticky flag set;
- ready is low whenever receive-full rises;
- the transmit interrupt is asserted with an empty queue;
- an overrun appears only on top of a full receive register.

Only the bench scenarios can show the data-dependent behaviour:
- the left-justified bit order on MISO for lengths 1, 4, 8 and 16;
- the residual upper bits in the receive register, checked against a model of every MOSI bit sent;
- the partial-character latch on deselect;
- the zero characters sent after the queue drains inside one long select window.

// File: rtl/spi_jslave_pkg.sv
package spi_jslave_pkg;
  localparam logic [1:0] ADDR_TX   = 2'd0;
  localparam logic [1:0] ADDR_RX   = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  localparam int STAT_RXFULL = 0;
  localparam int STAT_OVR    = 1;
  localparam int STAT_UDR    = 2;
  localparam int STAT_LVL    = 4;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_i,
  output logic s_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= {STAGES{RST_VAL}};
    else         q <= {q[STAGES-2:0], a_i};
  end

  assign s_o = q[STAGES-1];
endmodule

// File: rtl/spi_txfifo.sv
module spi_txfifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVW  = $clog2(DEPTH + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           push_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic           pop_i,
  output logic [DW-1:0]  head_o,
  output logic [LVW-1:0] level_o,
  output logic           full_o,
  output logic           empty_o
);
  logic [DW-1:0]  mem [DEPTH];
  logic [AW-1:0]  wr_ptr, rd_ptr;
  logic [LVW-1:0] cnt;
  logic           do_push, do_pop;

  assign full_o  = (cnt == LVW'(DEPTH));
  assign empty_o = (cnt == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem[rd_ptr];
  assign level_o = cnt;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= wdata_i;
  end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int DW   = 16,
  localparam int LW  = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_low_i,
  input  logic          cs_fall_i,
  input  logic          cs_rise_i,
  input  logic          sclk_rise_i,
  input  logic          sclk_fall_i,
  input  logic          mosi_i,
  input  logic [LW-1:0] len_m1_i,
  input  logic          fifo_empty_i,
  input  logic [DW-1:0] fifo_head_i,
  output logic          pop_o,
  output logic          underrun_o,
  output logic          done_o,
  output logic          latch_o,
  output logic [DW-1:0] rx_word_o,
  output logic          miso_o
);
  logic [DW-1:0] rx_sh, tx_sh;
  logic [LW-1:0] bit_cnt;
  logic          loaded;   // tx_sh holds a queue word, not zero fill
  logic          first;    // next rise is the first of a character
  logic          reload;   // next fall starts a new character
  logic          rise_act, fall_act, last_bit;

  assign rise_act = cs_low_i && sclk_rise_i;
  assign fall_act = cs_low_i && sclk_fall_i && !cs_fall_i;
  assign last_bit = (bit_cnt == len_m1_i);

  // queue word is committed on the first clock, so a deselect before it loses nothing
  assign pop_o      = rise_act && first && loaded;
  assign underrun_o = rise_act && first && !loaded;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_sh   <= '0;
      tx_sh   <= '0;
      bit_cnt <= '0;
      loaded  <= 1'b0;
      first   <= 1'b0;
      reload  <= 1'b0;
      done_o  <= 1'b0;
      latch_o <= 1'b0;
    end else begin
      done_o  <= rise_act && last_bit;
      latch_o <= cs_rise_i;
      if (cs_fall_i) begin
        tx_sh   <= fifo_empty_i ? '0 : fifo_head_i;
        loaded  <= !fifo_empty_i;
        first   <= 1'b1;
        reload  <= 1'b0;
        bit_cnt <= '0;
      end else if (cs_rise_i) begin
        first   <= 1'b0;
        reload  <= 1'b0;
        bit_cnt <= '0;
      end else if (rise_act) begin
        rx_sh <= {rx_sh[DW-2:0], mosi_i};
        first <= 1'b0;
        if (last_bit) begin
          bit_cnt <= '0;
          reload  <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end else if (fall_act) begin
        if (reload) begin
          tx_sh  <= fifo_empty_i ? '0 : fifo_head_i;
          loaded <= !fifo_empty_i;
          first  <= 1'b1;
          reload <= 1'b0;
        end else begin
          tx_sh <= {tx_sh[DW-2:0], 1'b0};
        end
      end
    end
  end

  assign rx_word_o = rx_sh;
  assign miso_o    = tx_sh[DW-1];
endmodule

// File: rtl/spi_jslave.sv
module spi_jslave
  import spi_jslave_pkg::*;
#(
  parameter int DW         = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int THR_W      = 2,
  localparam int LW        = $clog2(DW),
  localparam int LVW       = $clog2(FIFO_DEPTH + 1),
  localparam int STAT_FULL = STAT_LVL + LVW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_i,
  input  logic          cs_ni,
  input  logic          mosi_i,
  output logic          miso_o,
  output logic          miso_oe_o,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_tx_o,
  output logic          irq_rx_o,
  output logic          ready_o
);
  logic sclk_s, cs_s, mosi_s, sclk_d, cs_d;
  logic sclk_rise, sclk_fall, cs_fall, cs_rise, cs_low;

  spi_sync #(.RST_VAL(1'b0)) u_sync_sclk (.clk_i, .rst_ni, .a_i(sclk_i), .s_o(sclk_s));
  spi_sync #(.RST_VAL(1'b1)) u_sync_cs   (.clk_i, .rst_ni, .a_i(cs_ni),  .s_o(cs_s));
  spi_sync #(.RST_VAL(1'b0)) u_sync_mosi (.clk_i, .rst_ni, .a_i(mosi_i), .s_o(mosi_s));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_s;
    end
  end

  assign sclk_rise = sclk_s && !sclk_d;
  assign sclk_fall = !sclk_s && sclk_d;
  assign cs_fall   = !cs_s && cs_d;
  assign cs_rise   = cs_s && !cs_d;
  assign cs_low    = !cs_s;

  // control and status state
  logic [LW-1:0]    len_m1;
  logic [THR_W-1:0] tx_thr;
  logic [DW-1:0]    rx_buf;
  logic             rx_full, rx_ovr, tx_udr;

  // transmit queue
  logic           tx_push, tx_pop, tx_full, tx_empty;
  logic [DW-1:0]  tx_head;
  logic [LVW-1:0] tx_level;

  assign tx_push = reg_wr_i && (reg_addr_i == ADDR_TX);

  spi_txfifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk_i, .rst_ni,
    .push_i(tx_push), .wdata_i(reg_wdata_i),
    .pop_i(tx_pop), .head_o(tx_head),
    .level_o(tx_level), .full_o(tx_full), .empty_o(tx_empty)
  );

  // shift engine
  logic          udr_pulse, done_pulse, latch_pulse;
  logic [DW-1:0] rx_word;

  spi_shifter #(.DW(DW)) u_shift (
    .clk_i, .rst_ni,
    .cs_low_i(cs_low), .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
    .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall),
    .mosi_i(mosi_s), .len_m1_i(len_m1),
    .fifo_empty_i(tx_empty), .fifo_head_i(tx_head),
    .pop_o(tx_pop), .underrun_o(udr_pulse),
    .done_o(done_pulse), .latch_o(latch_pulse),
    .rx_word_o(rx_word), .miso_o(miso_o)
  );

  logic rx_rd, stat_wr;
  assign rx_rd   = reg_rd_i && (reg_addr_i == ADDR_RX);
  assign stat_wr = reg_wr_i && (reg_addr_i == ADDR_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_m1  <= LW'(7);
      tx_thr  <= '0;
      rx_buf  <= '0;
      rx_full <= 1'b0;
      rx_ovr  <= 1'b0;
      tx_udr  <= 1'b0;
    end else begin
      if (reg_wr_i && (reg_addr_i == ADDR_CTRL)) begin
        len_m1 <= reg_wdata_i[LW-1:0];
        tx_thr <= reg_wdata_i[LW +: THR_W];
      end
      if (done_pulse || latch_pulse) rx_buf <= rx_word;
      // a completing character wins over a same-cycle read
      if (done_pulse) begin
        rx_full <= 1'b1;
        if (rx_full && !rx_rd) rx_ovr <= 1'b1;
      end else if (rx_rd) begin
        rx_full <= 1'b0;
      end
      if (udr_pulse)                             tx_udr <= 1'b1;
      else if (stat_wr && reg_wdata_i[STAT_UDR]) tx_udr <= 1'b0;
      if (done_pulse && rx_full && !rx_rd)       rx_ovr <= 1'b1;
      else if (stat_wr && reg_wdata_i[STAT_OVR]) rx_ovr <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADDR_RX:   reg_rdata_o = rx_buf;
      ADDR_CTRL: begin
        reg_rdata_o[LW-1:0]    = len_m1;
        reg_rdata_o[LW +: THR_W] = tx_thr;
      end
      ADDR_STAT: begin
        reg_rdata_o[STAT_RXFULL]      = rx_full;
        reg_rdata_o[STAT_OVR]         = rx_ovr;
        reg_rdata_o[STAT_UDR]         = tx_udr;
        reg_rdata_o[STAT_LVL +: LVW]  = tx_level;
        reg_rdata_o[STAT_FULL]        = tx_full;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_tx_o  = (tx_level <= LVW'(tx_thr));
  assign irq_rx_o  = rx_full;
  assign ready_o   = !tx_empty && !rx_full;
  assign miso_oe_o = cs_low;
endmodule

// File: rtl/spi_jslave_chk.sv
module spi_jslave_chk #(
  parameter int DEPTH = 4,
  parameter int LVW   = 3
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           reg_wr_i,
  input logic [1:0]     reg_addr_i,
  input logic           miso_o,
  input logic           miso_oe_o,
  input logic           ready_o,
  input logic           irq_tx_o,
  input logic           irq_rx_o,
  input logic [LVW-1:0] tx_level,
  input logic           tx_pop,
  input logic           rx_full,
  input logic           rx_ovr,
  input logic           tx_udr,
  input logic           udr_pulse,
  input logic           sclk_fall,
  input logic           cs_fall
);
  assert_level_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_level <= LVW'(DEPTH));

  assert_full_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == 2'd0 && tx_level == LVW'(DEPTH) && !tx_pop)
      |=> tx_level == LVW'(DEPTH));

  assert_udr_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    udr_pulse |=> tx_udr);

  assert_miso_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miso_oe_o && !sclk_fall && !cs_fall) |=> $stable(miso_o));

  assert_irq_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_level == '0) |-> irq_tx_o);

  assert_ready_drop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_rx_o) |-> !ready_o);

  assert_ovr_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_ovr) |-> $past(rx_full));
endmodule

bind spi_jslave spi_jslave_chk #(.DEPTH(FIFO_DEPTH), .LVW(LVW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
  .miso_o(miso_o), .miso_oe_o(miso_oe_o), .ready_o(ready_o),
  .irq_tx_o(irq_tx_o), .irq_rx_o(irq_rx_o), .tx_level(tx_level),
  .tx_pop(tx_pop), .rx_full(rx_full), .rx_ovr(rx_ovr), .tx_udr(tx_udr),
  .udr_pulse(udr_pulse), .sclk_fall(sclk_fall), .cs_fall(cs_fall)
);

// File: tb/spi_jslave_bench.sv
module spi_jslave_bench;
  localparam int HALF = 6;
  localparam int NVEC = 5;
  // {len_m1[3:0], tx_word[15:0], mosi_bits[15:0]}
  localparam logic [35:0] VEC [NVEC] = '{
    {4'd7,  16'hA500, 16'h003C},
    {4'd7,  16'h5A00, 16'h00C3},
    {4'd3,  16'h9000, 16'h0006},
    {4'd15, 16'h1234, 16'hBEEF},
    {4'd0,  16'h8000, 16'h0001}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic        miso, miso_oe, irq_tx, irq_rx, ready;
  logic        wr = 1'b0, rd = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0, rdata;

  int checks = 0, errors = 0, oe_bad = 0;
  logic [15:0] rx_model = '0;
  logic [63:0] mi;
  logic [15:0] d;

  always #4 clk = ~clk;

  spi_jslave u_spi_jslave (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_tx_o(irq_tx), .irq_rx_o(irq_rx), .ready_o(ready)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [15:0] v);
    @(negedge clk); wr = 1'b1; addr = a; wdata = v;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; #1 v = rdata; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic xfer(input int n, input logic [63:0] mo, output logic [63:0] mr);
    mr = '0;
    @(negedge clk); cs_n = 1'b0;
    tick(8);
    for (int i = 0; i < n; i++) begin
      mosi = mo[n-1-i];
      tick(HALF);
      sclk = 1'b1;
      mr = {mr[62:0], miso};
      if (miso_oe !== 1'b1) oe_bad++;
      rx_model = {rx_model[14:0], mo[n-1-i]};
      tick(HALF);
      sclk = 1'b0;
    end
    tick(HALF);
    cs_n = 1'b1;
    tick(8);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    tick(3); rst_n = 1'b1; tick(2);

    // reset state
    reg_read(2'd3, d); check("R7 reset status", d, 16'h0000);
    reg_read(2'd2, d); check("R2 reset ctrl", d, 16'h0007);
    check("R8 reset irq_tx", irq_tx, 1'b1);
    check("R9 reset irq_rx", irq_rx, 1'b0);
    check("R11 reset ready", ready, 1'b0);
    check("R12 reset oe", miso_oe, 1'b0);

    // vector table: one character per entry
    for (int v = 0; v < NVEC; v++) begin
      int len;
      len = int'(VEC[v][35:32]) + 1;
      reg_write(2'd2, {12'd0, VEC[v][35:32]});
      reg_write(2'd0, VEC[v][31:16]);
      xfer(len, {48'd0, VEC[v][15:0]}, mi);
      check("R3 miso bits", mi, {48'd0, VEC[v][31:16] >> (16 - len)});
      check("R9 irq_rx set", irq_rx, 1'b1);
      reg_read(2'd1, d);
      check("R4 rx word", d, rx_model);
      reg_read(2'd3, d);
      check("R9 rx full cleared", d[0], 1'b0);
    end

    // R6 underrun: empty queue sends zeros
    reg_write(2'd2, 16'h0007);
    xfer(8, 64'h55, mi);
    check("R6 zero fill", mi, 64'd0);
    reg_read(2'd3, d); check("R6 underrun set", d[2], 1'b1);
    reg_write(2'd3, 16'h0004);
    reg_read(2'd3, d); check("R6 underrun cleared", d[2], 1'b0);
    reg_read(2'd1, d); check("R1 rx residual", d, rx_model);

    // R5 partial character latched on deselect
    xfer(4, 64'hA, mi);
    reg_read(2'd3, d); check("R5 partial no rx_full", d[0], 1'b0);
    reg_read(2'd1, d); check("R5 partial latch", d, rx_model);
    reg_write(2'd3, 16'h0004);

    // R7 full queue ignores fifth write
    reg_write(2'd0, 16'h1100);
    reg_write(2'd0, 16'h2200);
    reg_write(2'd0, 16'h3300);
    reg_write(2'd0, 16'h4400);
    reg_write(2'd0, 16'h5500);
    reg_read(2'd3, d);
    check("R7 level", d[6:4], 3'd4);
    check("R7 full flag", d[7], 1'b1);
    xfer(40, 64'd0, mi);
    check("R7 stream drops fifth", mi, 64'h1122334400);
    reg_read(2'd3, d);
    check("R10 overrun set", d[1], 1'b1);
    check("R7 level empty", d[6:4], 3'd0);
    reg_write(2'd3, 16'h0006);
    reg_read(2'd3, d); check("R10 overrun cleared", d[2:1], 2'b00);
    reg_read(2'd1, d); check("R1 rx after stream", d, rx_model);

    // R8 threshold
    reg_write(2'd3, 16'h0000);
    reg_write(2'd2, 16'h0027);
    reg_write(2'd0, 16'hAB00);
    reg_write(2'd0, 16'hCD00);
    tick(1); check("R8 irq at threshold", irq_tx, 1'b1);
    reg_write(2'd0, 16'hEF00);
    tick(1); check("R8 irq above threshold", irq_tx, 1'b0);
    xfer(24, 64'h123456, mi);
    check("R2 three 8-bit chars", mi, 64'hABCDEF);
    check("R8 irq after drain", irq_tx, 1'b1);
    reg_read(2'd1, d); check("R4 rx multi", d, 16'h3456);
    reg_write(2'd3, 16'h0006);

    // R11 ready
    check("R11 ready empty queue", ready, 1'b0);
    reg_write(2'd0, 16'h7700);
    tick(1); check("R11 ready with data", ready, 1'b1);
    xfer(8, 64'h81, mi);
    check("R11 ready drops", ready, 1'b0);
    reg_write(2'd0, 16'h6600);
    tick(1); check("R11 ready held by rx full", ready, 1'b0);
    reg_read(2'd1, d);
    tick(1); check("R11 ready after read", ready, 1'b1);
    xfer(8, 64'h00, mi);
    check("R3 last word", mi, 64'h66);

    // R12 output enable
    check("R12 oe while selected", oe_bad, 0);
    check("R12 oe deselected", miso_oe, 1'b0);

    finish_run();
  end
endmodule